// File: doc/BRIEF.md
# Timestamped Change-Only Capture Cluster Packer

This block sits between a logic-capture front end and a sample memory. Each sample period the front end presents one 16-bit word of pin levels and the current value of a free-running 16-bit tick counter. The packer keeps only the ticks on which the levels change. It groups those changes into clusters of eight memory words: one timestamp word followed by seven event words. The first event of a cluster belongs to the timestamp tick, and each later event belongs to the tick after the one before it.

A change that follows an idle gap starts a new cluster, and so does a change that arrives when the current cluster is full. A new cluster is also forced whenever the tick has moved a whole 16-bit period past the cluster timestamp, so a reader can always resolve counter rollover. Event slots that a cluster never used are filled with its last value, so a reader sees no change in them. Finished clusters go out one word per clock through a plain word-write port. The write address is a row field above a 9-bit in-row word field, and it wraps back to zero after the last row.

The front end must present a sample no more often than once every eight clocks, because a finished cluster takes eight clocks to drain. A start pulse clears the address, the wrap flag and the event counter and then begins capture. A stop pulse ends capture and flushes any open cluster. `busy` stays high until the last word of that cluster has been written.

Top module: `rle_cluster_packer`

## Requirements
- R1: After reset, `wr_en`, `busy` and `wrapped` are 0 and `evt_count` is 0.
- R2: Each cluster is written as eight back-to-back words at consecutive addresses, starting at an address whose low three bits are 0. The first word holds the timestamp with its low byte in bits 15:8 and its high byte in bits 7:0. The next seven words are the event slots in order, each written unchanged (high byte in bits 15:8).
- R3: The first accepted sample after start opens a cluster whose timestamp is that sample's tick and whose first event is that sample. A later sample equal to the last stored event, with no forced cluster due, stores nothing.
- R4: A changed sample whose tick is exactly one more than the tick of the last stored event is appended to the open cluster when that cluster holds fewer than seven events.
- R5: A changed sample whose tick is not consecutive, or that arrives when the open cluster holds seven events, closes that cluster and opens a new one. In the closed cluster, every unused slot repeats the last stored event.
- R6: When an accepted sample's tick minus the open cluster's timestamp (modulo 2^16) is at least 0xFFFF, the open cluster is closed and a new one is opened with that tick and sample, whether or not the level changed.
- R7: A stop pulse during capture closes any open cluster. `busy` stays 1 until that cluster's last word is written and then falls to 0. `wr_en` is never 1 while `busy` is 0.
- R8: The write address rises by one for each word written. Its upper field selects the row and its lower 9 bits select the word within the row. After the last word of the last row it wraps to 0 and sets `wrapped`, which stays set until the next accepted start.
- R9: `evt_count` counts stored events (fill slots are not counted) and is cleared by an accepted start.
- R10: A start pulse while `busy` is 1 is ignored. Samples presented while not capturing are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_start | input | 1 | One-cycle pulse that begins a capture |
| cap_stop | input | 1 | One-cycle pulse that ends a capture and flushes |
| smp_valid | input | 1 | Sample word and tick are valid this cycle |
| smp_data | input | 16 | Pin levels for this sample period |
| smp_tick | input | 16 | Free-running tick counter value for this sample |
| wr_en | output | 1 | Memory word write strobe |
| wr_addr | output | ROW_BITS+WORD_BITS (24) | Word address: row above in-row word |
| wr_data | output | 16 | Word to write |
| evt_count | output | CNT_W (24) | Number of stored events |
| busy | output | 1 | Capturing, or still draining a cluster |
| wrapped | output | 1 | Write address has wrapped past the last row |

## Verification
Corrupted staging state, such as a wrong slot count or a stale last-event tick, changes the choice between appending and opening. That shows up in the very next cluster written, as a wrong timestamp word or a wrong fill value, at most eight clocks after the close. A slip in the drain index or the address counter misplaces or reorders words inside a burst, and that is visible on the first word that follows. Wrong capture control shows up as writes after `busy` falls or as an event count that does not match the stored changes.

// File: rtl/rcp_pkg.sv
// Package: shared widths and the cluster record used by the packer.
// Assumes a 16-bit sample word and a fixed eight-word cluster.
package rcp_pkg;
    localparam int SMP_W     = 16;
    localparam int EVT_SLOTS = 7;
    localparam int CL_WORDS  = EVT_SLOTS + 1;
    localparam int IDX_W     = $clog2(CL_WORDS);

    typedef logic [SMP_W-1:0] word_t;

    typedef struct packed {
        word_t                     ts;
        logic [EVT_SLOTS-1:0][SMP_W-1:0] ev;
    } cluster_t;
endpackage

// File: rtl/rcp_ctrl.sv
// Module: capture control. Turns start/stop pulses into a run state.
// A start is accepted only while idle. A stop is accepted only while
// running and produces a one-cycle flush request.
module rcp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_start,
    input  logic cap_stop,
    input  logic drain_act,
    output logic running,
    output logic clr,
    output logic flush,
    output logic busy
);
    assign busy  = running | drain_act;
    assign clr   = cap_start & ~busy;
    assign flush = cap_stop & running;

    // run state: set by an accepted start, cleared by stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (clr) begin
            running <= 1'b1;
        end else if (flush) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/rcp_builder.sv
// Module: cluster builder. Decides per accepted sample whether to open a
// cluster, append an event or store nothing. Keeps the open cluster with
// unused slots already holding the last event, so a close hands over a
// complete record. Assumes the drain is free whenever close_o pulses.
module rcp_builder
    import rcp_pkg::*;
#(
    parameter logic [15:0] FORCE_SPAN = 16'hFFFF,
    parameter int          CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             flush,
    input  logic             acc_valid,
    input  word_t            smp_data,
    input  word_t            smp_tick,
    output logic             close_o,
    output cluster_t         close_cl,
    output logic [CNT_W-1:0] evt_count
);
    logic           is_open;
    cluster_t       cur;
    logic [IDX_W-1:0] n_ev;
    word_t          last_val;
    word_t          last_tick;

    word_t span;
    logic  force_new, changed, contig, full, do_open, do_append;

    // next-action decode for the current sample
    always_comb begin
        span      = word_t'(smp_tick - cur.ts);
        force_new = is_open && (span >= FORCE_SPAN);
        changed   = (smp_data != last_val);
        contig    = (smp_tick == word_t'(last_tick + 16'd1));
        full      = (n_ev == IDX_W'(EVT_SLOTS));
        do_open   = acc_valid && (!is_open || force_new ||
                                  (changed && (!contig || full)));
        do_append = acc_valid && is_open && !force_new && changed && contig && !full;
    end

    assign close_o  = is_open && (do_open || flush);
    assign close_cl = cur;

    // staging cluster and event bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            is_open   <= 1'b0;
            cur       <= '0;
            n_ev      <= '0;
            last_val  <= '0;
            last_tick <= '0;
            evt_count <= '0;
        end else if (do_open) begin
            is_open   <= 1'b1;
            cur.ts    <= smp_tick;
            for (int i = 0; i < EVT_SLOTS; i++) begin
                cur.ev[i] <= smp_data;
            end
            n_ev      <= IDX_W'(1);
            last_val  <= smp_data;
            last_tick <= smp_tick;
            evt_count <= evt_count + 1'b1;
        end else if (do_append) begin
            for (int i = 0; i < EVT_SLOTS; i++) begin
                if (IDX_W'(i) >= n_ev) begin
                    cur.ev[i] <= smp_data;
                end
            end
            n_ev      <= n_ev + 1'b1;
            last_val  <= smp_data;
            last_tick <= smp_tick;
            evt_count <= evt_count + 1'b1;
        end else if (flush) begin
            is_open   <= 1'b0;
        end
    end
endmodule

// File: rtl/rcp_drain.sv
// Module: cluster drain. Holds a closed cluster in a shadow register and
// writes its eight words on consecutive cycles, timestamp first with the
// bytes swapped. Owns the word address and the wrap flag. Assumes no new
// load arrives before the current burst reaches its last word.
module rcp_drain
    import rcp_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  cluster_t      load_cl,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output word_t         wr_data,
    output logic          wrapped,
    output logic          active
);
    cluster_t         shadow;
    logic [IDX_W-1:0] idx;
    logic [CL_WORDS-1:0][SMP_W-1:0] words;

    // word 0: timestamp, low byte placed first on the bus
    assign words[0] = {shadow.ts[7:0], shadow.ts[15:8]};

    genvar g;
    generate
        for (g = 1; g < CL_WORDS; g++) begin : g_evt
            assign words[g] = shadow.ev[g-1];
        end
    endgenerate

    assign wr_en   = active;
    assign wr_data = words[idx];

    // burst sequencing and shadow load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (load) begin
            shadow <= load_cl;
            idx    <= '0;
            active <= 1'b1;
        end else if (active) begin
            idx    <= idx + 1'b1;
            active <= (idx != IDX_W'(CL_WORDS - 1));
        end
    end

    // word address and sticky wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_addr <= '0;
            wrapped <= 1'b0;
        end else if (active) begin
            wr_addr <= wr_addr + 1'b1;
            if (&wr_addr) begin
                wrapped <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rle_cluster_packer.sv
// Module: top of the change-only capture packer. Wires control, builder
// and drain. Assumes smp_valid is high at most once every eight clocks.
module rle_cluster_packer
    import rcp_pkg::*;
#(
    parameter int          ROW_BITS   = 15,
    parameter int          WORD_BITS  = 9,
    parameter int          CNT_W      = 24,
    parameter logic [15:0] FORCE_SPAN = 16'hFFFF,
    localparam int         AW         = ROW_BITS + WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_start,
    input  logic             cap_stop,
    input  logic             smp_valid,
    input  logic [15:0]      smp_data,
    input  logic [15:0]      smp_tick,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [15:0]      wr_data,
    output logic [CNT_W-1:0] evt_count,
    output logic             busy,
    output logic             wrapped
);
    logic     running, clr, flush, drain_act, acc_valid, close_p;
    cluster_t close_cl;

    assign acc_valid = running & smp_valid & ~cap_stop;

    rcp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_start (cap_start),
        .cap_stop  (cap_stop),
        .drain_act (drain_act),
        .running   (running),
        .clr       (clr),
        .flush     (flush),
        .busy      (busy)
    );

    rcp_builder #(
        .FORCE_SPAN (FORCE_SPAN),
        .CNT_W      (CNT_W)
    ) u_build (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .flush     (flush),
        .acc_valid (acc_valid),
        .smp_data  (smp_data),
        .smp_tick  (smp_tick),
        .close_o   (close_p),
        .close_cl  (close_cl),
        .evt_count (evt_count)
    );

    rcp_drain #(
        .AW (AW)
    ) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load    (close_p),
        .load_cl (close_cl),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrapped (wrapped),
        .active  (drain_act)
    );
endmodule

// File: rtl/rcp_chk.sv
// Module: port-level checker for the packer, bound to every instance.
module rcp_chk #(
    parameter int AW    = 24,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [CNT_W-1:0] evt_count,
    input logic             busy,
    input logic             wrapped
);
    // R7
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R2
    burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:0] != 3'd7) |=> wr_en);

    // R2
    burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (wr_addr[2:0] == 3'd0));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:0] != 3'd7) |=> (wr_addr == AW'($past(wr_addr) + 1'b1)));

    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrapped) |-> ($past(wr_en) && (&$past(wr_addr))));

    // R9
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(evt_count) |-> (evt_count == CNT_W'($past(evt_count) + 1'b1) || evt_count == '0));
endmodule

bind rle_cluster_packer rcp_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .evt_count (evt_count),
    .busy      (busy),
    .wrapped   (wrapped)
);

// File: tb/rle_cluster_packer_bench.sv
module rle_cluster_packer_bench;
    localparam int ROWB = 1;
    localparam int AWB  = ROWB + 9;
    localparam int AMASK = (1 << AWB) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_start = 1'b0, cap_stop = 1'b0, smp_valid = 1'b0;
    logic [15:0] smp_data = '0, smp_tick = '0;
    logic        wr_en, busy, wrapped;
    logic [AWB-1:0] wr_addr;
    logic [15:0] wr_data;
    logic [23:0] evt_count;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // expected write stream
    int unsigned q_addr[$];
    int unsigned q_data[$];
    string       q_tag[$];

    // reference state
    bit          m_open, m_wrapped;
    logic [15:0] m_ts, m_last, m_ltick;
    logic [15:0] m_ev[7];
    int          m_n, m_evt;
    int unsigned m_addr;

    always #5 clk = ~clk;

    rle_cluster_packer #(.ROW_BITS(ROWB)) u_rle_cluster_packer (
        .clk, .rst_n, .cap_start, .cap_stop, .smp_valid, .smp_data, .smp_tick,
        .wr_en, .wr_addr, .wr_data, .evt_count, .busy, .wrapped
    );

    task automatic check(bit ok, string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic void push_word(int unsigned d, string tag);
        q_addr.push_back(m_addr);
        q_data.push_back(d);
        q_tag.push_back(tag);
        if (m_addr == AMASK) m_wrapped = 1;
        m_addr = (m_addr + 1) & AMASK;
    endfunction

    function automatic void m_close(string tag);
        push_word({16'(m_ts[7:0]) << 8} | m_ts[15:8], tag);
        for (int i = 0; i < 7; i++) push_word(m_ev[i], tag);
        m_open = 0;
    endfunction

    function automatic void m_openc(logic [15:0] d, logic [15:0] t);
        m_open = 1; m_ts = t; m_n = 1; m_last = d; m_ltick = t; m_evt++;
        for (int i = 0; i < 7; i++) m_ev[i] = d;
    endfunction

    function automatic void m_sample(logic [15:0] d, logic [15:0] t);
        logic [15:0] span, nx;
        span = t - m_ts;
        nx   = m_ltick + 16'd1;
        if (!m_open) m_openc(d, t);
        else if (span >= 16'hFFFF) begin m_close("R6"); m_openc(d, t); end
        else if (d != m_last) begin
            if (m_n < 7 && t == nx) begin
                for (int i = 0; i < 7; i++) if (i >= m_n) m_ev[i] = d;
                m_n++; m_last = d; m_ltick = t; m_evt++;
            end else begin
                m_close("R5"); m_openc(d, t);
            end
        end
    endfunction

    // drive one sample, then leave the required idle spacing
    task automatic sample(logic [15:0] d, logic [15:0] t, bit model);
        @(negedge clk);
        smp_valid = 1; smp_data = d; smp_tick = t;
        if (model) m_sample(d, t);
        @(negedge clk);
        smp_valid = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); cap_start = 1;
        m_open = 0; m_addr = 0; m_wrapped = 0; m_evt = 0;
        @(negedge clk); cap_start = 0;
    endtask

    task automatic stop_and_drain();
        @(negedge clk); cap_stop = 1;
        if (m_open) m_close("R7");
        @(negedge clk); cap_stop = 0;
        check(busy == 1'b1, "R7 busy during flush", busy, 1);
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        check(busy == 1'b0, "R7 busy falls", busy, 0);
        check(q_addr.size() == 0, "R7 all words written", q_addr.size(), 0);
        check(evt_count == 24'(m_evt), "R9 event count", evt_count, m_evt);
    endtask

    // compare each write with the expected stream
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_addr.size() == 0) begin
                check(0, "R10 unexpected write", wr_addr, 0);
            end else begin
                string tg;
                int unsigned ea, ed;
                ea = q_addr.pop_front(); ed = q_data.pop_front(); tg = q_tag.pop_front();
                check(wr_addr == AWB'(ea), {tg, " R8 address"}, wr_addr, ea);
                check(wr_data == 16'(ed), {tg, " R2 data"}, wr_data, ed);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, t;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(wr_en == 0, "R1 wr_en", wr_en, 0);
        check(busy == 0, "R1 busy", busy, 0);
        check(wrapped == 0, "R1 wrapped", wrapped, 0);
        check(evt_count == 0, "R1 evt_count", evt_count, 0);

        // R10 samples before start are ignored
        sample(16'h1234, 16'd5, 0);
        check(evt_count == 0 && !wr_en, "R10 idle sample", evt_count, 0);

        pulse_start();
        // R3 first sample opens, repeat stores nothing
        sample(16'hA5A5, 16'd10, 1);
        sample(16'hA5A5, 16'd11, 1);
        check(evt_count == 1, "R3 unchanged not stored", evt_count, 1);
        // R5 change after gap, then R4 run of consecutive changes past seven
        t = 16'd12;
        for (int i = 0; i < 9; i++) begin
            sample(16'h0100 + 16'(i), t, 1);
            t = t + 16'd1;
        end
        check(evt_count == 24'(m_evt), "R4 appended events", evt_count, m_evt);
        // R6 forced cluster at a full tick period, none one tick earlier
        t = m_ts + 16'hFFFE;
        sample(m_last, t, 1);
        t = m_ts + 16'hFFFF;
        sample(m_last, t, 1);
        check(evt_count == 24'(m_evt), "R6 forced event count", evt_count, m_evt);

        // random patterns
        d = 16'h0; t = t + 16'd1;
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 3 != 0) d = 16'($urandom);
            t = t + (($urandom % 4 == 0) ? 16'(2 + $urandom % 3) : 16'd1);
            sample(d, t, 1);
        end

        // R7 stop with start attempt during drain (R10)
        @(negedge clk); cap_stop = 1;
        if (m_open) m_close("R7");
        @(negedge clk); cap_stop = 0; cap_start = 1;
        check(busy == 1'b1, "R7 busy during flush", busy, 1);
        @(negedge clk); cap_start = 0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        check(busy == 0, "R7 busy falls", busy, 0);
        check(q_addr.size() == 0, "R7 all words written", q_addr.size(), 0);
        check(evt_count == 24'(m_evt), "R10 start while busy ignored", evt_count, m_evt);
        sample(16'h7777, 16'd3, 0);
        sample(16'h8888, 16'd4, 0);
        check(evt_count == 24'(m_evt), "R10 samples after stop ignored", evt_count, m_evt);

        // R8 address wrap over both rows, R9 cleared on start
        pulse_start();
        @(negedge clk);
        check(evt_count == 0, "R9 cleared by start", evt_count, 0);
        check(wrapped == 0, "R8 wrapped cleared", wrapped, 0);
        t = 16'd100;
        for (int i = 0; i < 140; i++) begin
            t = t + 16'd2;
            sample(16'(i * 37 + 1), t, 1);
        end
        stop_and_drain();
        check(wrapped == 1'b1 && m_wrapped, "R8 wrapped set", wrapped, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule